// File: doc/BRIEF.md
# Fractional-Step Baud Tick Generator

This block turns a fast system clock into a stream of one-cycle baud ticks. It does this in two stages. An integer prescaler first divides the system clock by a programmable amount. A 17-bit phase accumulator then adds a programmable step on every prescaled enable. Each time the accumulator wraps past its 2^17 modulus, the block emits one tick. The leftover phase stays in the accumulator, so the long-run tick rate is clk / (scale+1) × step / 2^17. This holds even when that rate is not an integer fraction of the system clock.

Software sets the rate with one 32-bit register write, which carries both the prescale and the step fields. Every write restarts the phase from zero. The first tick after a write therefore always arrives at a known time, whatever the state of the previous setting. The tick output feeds a serial transmitter or receiver, which counts ticks to build bit periods.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both fields read as zero. The tick output is low and stays low until the configuration register is written.
- R2: A configuration write takes the prescale field from bits 27:16 and the step field from bits 15:0. Bits 31:28 and 15:0's neighbours 28..31 have no effect on the tick stream.
- R3: Over a long window after a write, the number of ticks equals floor(floor(N/(scale+1)) × step / 2^17) within ±1, where N is the number of elapsed clocks.
- R4: A prescale value of 0 makes the prescaler enable every system clock. With step 0x8000, ticks then recur exactly every 4 clocks.
- R5: A step value of 0 produces no ticks at all.
- R6: The tick is high for exactly one clock per accumulator carry. It is never high on two consecutive clocks.
- R7: A configuration write clears the prescale counter and the phase accumulator in the cycle it is accepted. The tick is low in the following cycle. The first tick then falls exactly (scale+1) × ceil(2^17/step) clocks after the write edge.
- R8: A tick only follows a clock in which the prescaler produced an enable. The prescale counter never exceeds the programmed prescale value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration word: prescale in 27:16, step in 15:0 |
| baud_tick | output | 1 | One-clock baud tick |

## Verification
A write is accepted at clock edge E0, and both counters are zero right after that edge. The prescaler's enable for edge Ek is decided in the cycle before Ek. Any carry is registered at that same edge, so a tick is visible right after edge Ek, when k is a multiple of scale+1 that completes a wrap. The bench drops the strobe at the first falling edge after E0. It then samples the tick once at each falling edge after E1..EN and compares the total against the rate formula. For first-tick latency, the bench counts falling edges from the write until the first high sample and compares the count with (scale+1) × ceil(2^17/step).

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
    localparam int unsigned DEF_REG_W     = 32;
    localparam int unsigned DEF_SCALE_W   = 12;
    localparam int unsigned DEF_STEP_W    = 16;
    localparam int unsigned DEF_ACC_W     = 17;
    localparam int unsigned DEF_SCALE_LSB = 16;
    localparam int unsigned DEF_STEP_LSB  = 0;
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
    parameter int unsigned REG_W     = 32,
    parameter int unsigned SCALE_W   = 12,
    parameter int unsigned STEP_W    = 16,
    parameter int unsigned SCALE_LSB = 16,
    parameter int unsigned STEP_LSB  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [REG_W-1:0]   wdata,
    output logic [SCALE_W-1:0] scale,
    output logic [STEP_W-1:0]  step
);
    localparam int unsigned SCALE_MSB = SCALE_LSB + SCALE_W - 1;
    localparam int unsigned STEP_MSB  = STEP_LSB + STEP_W - 1;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [STEP_W-1:0]  step;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.scale = wdata[SCALE_MSB:SCALE_LSB];
            cfg_d.step  = wdata[STEP_MSB:STEP_LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign scale = cfg_q.scale;
    assign step  = cfg_q.step;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int unsigned SCALE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SCALE_W-1:0] scale,
    output logic               en,
    output logic [SCALE_W-1:0] cnt
);
    typedef struct packed {
        logic [SCALE_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic hit;

    always_comb begin
        pre_d = pre_q;
        hit   = (pre_q.cnt == scale) && !restart;
        if (restart || hit) pre_d.cnt = '0;
        else                pre_d.cnt = pre_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign en  = hit;
    assign cnt = pre_q.cnt;
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
    parameter int unsigned STEP_W = 16,
    parameter int unsigned ACC_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              en,
    input  logic [STEP_W-1:0] step,
    output logic              tick
);
    localparam int unsigned SUM_W = ACC_W + 1;
    localparam int unsigned PAD_W = SUM_W - STEP_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } ph_t;

    ph_t ph_d, ph_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        ph_d      = ph_q;
        ph_d.tick = 1'b0;
        sum       = {1'b0, ph_q.acc} + {{PAD_W{1'b0}}, step};
        if (restart) begin
            ph_d.acc = '0;
        end else if (en) begin
            ph_d.acc  = sum[ACC_W-1:0];
            ph_d.tick = sum[ACC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign tick = ph_q.tick;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int unsigned REG_W     = DEF_REG_W,
    parameter int unsigned SCALE_W   = DEF_SCALE_W,
    parameter int unsigned STEP_W    = DEF_STEP_W,
    parameter int unsigned ACC_W     = DEF_ACC_W,
    parameter int unsigned SCALE_LSB = DEF_SCALE_LSB,
    parameter int unsigned STEP_LSB  = DEF_STEP_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic             baud_tick
);
    logic [SCALE_W-1:0] cfg_scale;
    logic [STEP_W-1:0]  cfg_step;
    logic               presc_en;
    logic [SCALE_W-1:0] presc_cnt;

    baud_cfg_reg #(
        .REG_W(REG_W), .SCALE_W(SCALE_W), .STEP_W(STEP_W),
        .SCALE_LSB(SCALE_LSB), .STEP_LSB(STEP_LSB)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .scale(cfg_scale), .step(cfg_step)
    );

    baud_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(cfg_we), .scale(cfg_scale),
        .en(presc_en), .cnt(presc_cnt)
    );

    baud_phase_acc #(.STEP_W(STEP_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .restart(cfg_we), .en(presc_en),
        .step(cfg_step), .tick(baud_tick)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int unsigned SCALE_W = 12,
    parameter int unsigned STEP_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic               baud_tick,
    input logic               presc_en,
    input logic [SCALE_W-1:0] presc_cnt,
    input logic [SCALE_W-1:0] cfg_scale,
    input logic [STEP_W-1:0]  cfg_step
);
    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);
    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !baud_tick);
    // R5
    zero_step_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_step == '0 && !cfg_we) |=> !baud_tick);
    // R8
    tick_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(presc_en));
    // R8
    presc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presc_cnt <= cfg_scale);
    // R4
    scale_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_scale == '0 && !cfg_we) |-> presc_en);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .baud_tick(baud_tick),
    .presc_en(presc_en), .presc_cnt(presc_cnt),
    .cfg_scale(cfg_scale), .cfg_step(cfg_step)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        baud_tick;

    int checks = 0;
    int errors = 0;
    int wide_pulses = 0;
    logic prev_tick = 1'b0;

    always #2 clk = ~clk;

    baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .baud_tick(baud_tick)
    );

    always @(negedge clk) begin
        if (rst_n && baud_tick && prev_tick) wide_pulses++;
        prev_tick = rst_n && baud_tick;
    end

    function automatic longint exp_ticks(longint n, longint s, longint st);
        return ((n / (s + 1)) * st) >> 17;
    endfunction

    function automatic longint exp_first(longint s, longint st);
        return (s + 1) * ((131072 + st - 1) / st);
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic count_ticks(int n, output longint cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (baud_tick) cnt++;
        end
    endtask

    task automatic first_tick(int limit, output longint at);
        at = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (baud_tick) begin
                at = i;
                break;
            end
        end
    endtask

    initial begin
        #(150000 * 4);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint got, expv, diff;
        int s, st;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(baud_tick == 1'b0, "R1 tick low in reset", baud_tick, 0);
        rst_n = 1'b1;
        count_ticks(300, got);
        chk(got == 0, "R1 no ticks before write", got, 0);

        // R2: top nibble set, scale=1 step=0x8000 -> tick every 8 clocks
        wr(32'hF001_8000);
        count_ticks(800, got);
        chk(got == exp_ticks(800, 1, 32768), "R2 field placement", got, exp_ticks(800, 1, 32768));
        wr(32'h0001_8000);
        count_ticks(800, expv);
        chk(got == expv, "R2 bits 31:28 ignored", got, expv);

        // R4: scale 0, step 0x8000, period 4
        wr(32'h0000_8000);
        first_tick(20, got);
        chk(got == 4, "R4 first tick scale0", got, 4);
        count_ticks(400, got);
        chk(got == 100, "R4 every clock enabled", got, 100);

        // R5: step 0
        wr(32'h0003_0000);
        count_ticks(2000, got);
        chk(got == 0, "R5 zero step silent", got, 0);

        // R7: rewrite mid-phase restarts cleanly
        wr(32'h0002_4000);
        repeat (13) @(negedge clk);
        wr(32'h0002_4000);
        first_tick(200, got);
        chk(got == exp_first(2, 16384), "R7 first tick after rewrite", got, exp_first(2, 16384));
        wr(32'h0005_2E5B);
        first_tick(2000, got);
        chk(got == exp_first(5, 11867), "R7 first tick odd step", got, exp_first(5, 11867));

        // R3: max step at scale 0 and random configurations
        wr(32'h0000_FFFF);
        count_ticks(3000, got);
        expv = exp_ticks(3000, 0, 65535);
        diff = got - expv;
        chk(diff <= 1 && diff >= -1, "R3 max step rate", got, expv);
        for (int k = 0; k < 10; k++) begin
            s  = $urandom_range(0, 15);
            st = $urandom_range(1, 65535);
            wr({4'hA, s[11:0], st[15:0]});
            count_ticks(3000, got);
            expv = exp_ticks(3000, s, st);
            diff = got - expv;
            chk(diff <= 1 && diff >= -1, "R3 random rate", got, expv);
        end

        chk(wide_pulses == 0, "R6 single-cycle ticks", wide_pulses, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule